// File: doc/BRIEF.md
# Key-Locked System Control Register Bank

This block is a bank of 32-bit system control registers on a simple word-addressed bus. The bus carries a write strobe, a read strobe, a 12-bit byte address (bits 1:0 ignored, so a 4 KB window of 1024 words), write data and read data. Software must present a 16-bit magic key to an unlock register before ordinary registers accept writes. A second key on a lock register closes the bank again. The bank comes out of reset locked.

Every word offset is decoded to one of four access classes: read-write, read-only, write-only or unmapped. An access that breaks its class is flagged with a one-cycle error pulse. A write that is illegal, or that arrives while the bank is locked, is also dropped. A small control word and the two key registers stay writable while the bank is locked.

Only a representative subset of the registers has storage or a fixed value. These are the three PLL control words, the three PLL configuration words, a PLL status word, the reset-control word, the reset-reason word, a boot-mode word and four throttle status words. The other mapped read-write words accept writes and read as zero. An accepted write to the reset-control word with bit 0 set raises a one-cycle soft-reset request.

Top module: `sysctl_keylock_bank`

## Requirements
- R1: After reset the lock status (byte 0x00C, bit 0) reads 1. PLL control words 0x100/0x104/0x108 read 0x0001A008, PLL config words 0x110/0x114/0x118 read 0x00014000, PLL status 0x10C reads 0x0000003F, boot mode 0x25C reads 0x00000001, reset reason 0x250 reads 0x00000040, and a mapped read-write word without storage (0x120) reads 0. The outputs rdData, accessErr and softRstReq are 0.
- R2: rdData takes the selected word at the clock edge that samples rdEn and holds it until the next read. Byte address bits 1:0 do not affect the word selected.
- R3: A write to byte 0x004 whose low 16 bits are 0x767B sets the lock status to 1. A write to byte 0x008 whose low 16 bits are 0xDF0D clears it to 0. The upper 16 bits are ignored, and any other key leaves the status unchanged.
- R4: While the lock status is 1, a write to any read-write or write-only word other than bytes 0x000, 0x004 and 0x008 is discarded and flags an error.
- R5: Byte 0x000 keeps only bit 0 of a write (other bits read 0) and accepts writes whether or not the bank is locked.
- R6: A write to a read-only word (such as 0x00C or 0x10C) or to an unmapped word (such as 0x3FC) is discarded and flags an error.
- R7: A read of a write-only word (0x004, 0x008, 0x60C, 0x614) or of an unmapped word returns 0 and flags an error.
- R8: accessErr is high for exactly the one cycle after the offending strobe and stays low after legal accesses.
- R9: An accepted write to byte 0x200 with bit 0 set pulses softRstReq for the one cycle after the write, and the value is stored. A write with bit 0 clear, or a write while locked, gives no pulse.
- R10: An accepted write to a stored read-write word keeps all 32 bits and reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| rdEn | input | 1 | Read strobe, one cycle per read |
| addr | input | 12 | Byte address; bits 1:0 ignored |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, registered |
| accessErr | output | 1 | One-cycle pulse on an illegal or locked access |
| softRstReq | output | 1 | One-cycle soft-reset request |

## Verification
Every result of this bank is due one clock edge after the strobe that causes it:
- read data,
- the access-error pulse,
- the soft-reset pulse,
- the new lock state.

The bench raises a strobe on a falling edge and drops it on the next falling edge. It samples all three outputs at that same falling edge, half a cycle after the edge that registered them. A separate check samples before that edge, to confirm that read data has not yet changed. An idle-cycle check confirms that the error pulse has already fallen.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int BYTE_ADDR_W = 12;
  localparam int WORD_W      = BYTE_ADDR_W - 2;
  localparam int DATA_W      = 32;
  localparam int KEY_W       = 16;

  localparam logic [KEY_W-1:0] LOCK_KEY   = 16'h767B;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'hDF0D;

  localparam logic [WORD_W-1:0] W_CTRL    = 10'h000;
  localparam logic [WORD_W-1:0] W_LOCK    = 10'h001;
  localparam logic [WORD_W-1:0] W_UNLOCK  = 10'h002;
  localparam logic [WORD_W-1:0] W_LOCKSTA = 10'h003;
  localparam logic [WORD_W-1:0] W_RSTCTL  = 10'h080;

  typedef enum logic [1:0] {ACC_NONE, ACC_RO, ACC_WO, ACC_RW} acc_e;

  typedef struct packed {
    logic storeEn;
    logic ctrlBitWr;
    logic rdLatch;
  } strobe_t;

  localparam int NUM_STORE = 8;

  function automatic logic [WORD_W-1:0] storeIdx(input int i);
    case (i)
      0: return 10'h040;
      1: return 10'h041;
      2: return 10'h042;
      3: return 10'h044;
      4: return 10'h045;
      5: return 10'h046;
      6: return W_RSTCTL;
      default: return 10'h094;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] storeInit(input int i);
    if (i < 3) return 32'h0001A008;
    if (i < 6) return 32'h00014000;
    if (i == 6) return 32'h0;
    return 32'h00000040;
  endfunction

  function automatic logic [DATA_W:0] roConst(input logic [WORD_W-1:0] w);
    case (w)
      10'h043: return {1'b1, 32'h0000003F};
      10'h097: return {1'b1, 32'h00000001};
      10'h05F, 10'h063, 10'h067, 10'h06B: return {1'b1, 32'h00010000};
      default: return '0;
    endcase
  endfunction

  function automatic acc_e classify(input logic [WORD_W-1:0] w);
    case (w) inside
      W_LOCKSTA, 10'h043, 10'h05F, 10'h063, 10'h067, 10'h06B,
      10'h097, 10'h14C, 10'h186, 10'h188:          return ACC_RO;
      W_LOCK, W_UNLOCK, 10'h183, 10'h185:          return ACC_WO;
      W_CTRL, [10'h040:10'h042], [10'h044:10'h046],
      [10'h048:10'h05B], [10'h05C:10'h05E], [10'h060:10'h062],
      [10'h064:10'h066], [10'h068:10'h06A], 10'h06E,
      [10'h070:10'h071], [10'h080:10'h08E], [10'h090:10'h091],
      [10'h093:10'h094], 10'h096, [10'h1C0:10'h1F5]: return ACC_RW;
      default:                                      return ACC_NONE;
    endcase
  endfunction

endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [WORD_W-1:0] wordIdx,
  input  logic [KEY_W-1:0]  keyBits,
  input  logic              softBit,
  output strobe_t           stb,
  output logic              lockSta,
  output logic              accessErr,
  output logic              softRstReq
);

  acc_e cls;
  logic bypass;
  logic wrLegal;
  logic wrAccept;
  logic wrBad;
  logic rdBad;

  always_comb begin
    cls      = classify(wordIdx);
    bypass   = (wordIdx == W_CTRL) || (wordIdx == W_LOCK) || (wordIdx == W_UNLOCK);
    wrLegal  = (cls == ACC_RW) || (cls == ACC_WO);
    wrAccept = wrEn && wrLegal && (!lockSta || bypass);
    wrBad    = wrEn && !wrAccept;
    rdBad    = rdEn && ((cls == ACC_WO) || (cls == ACC_NONE));
    stb.storeEn   = wrAccept;
    stb.ctrlBitWr = wrAccept && (wordIdx == W_CTRL);
    stb.rdLatch   = rdEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockSta    <= 1'b1;
      accessErr  <= 1'b0;
      softRstReq <= 1'b0;
    end else begin
      if (wrAccept && wordIdx == W_LOCK && keyBits == LOCK_KEY)
        lockSta <= 1'b1;
      else if (wrAccept && wordIdx == W_UNLOCK && keyBits == UNLOCK_KEY)
        lockSta <= 1'b0;
      accessErr  <= wrBad || rdBad;
      softRstReq <= wrAccept && (wordIdx == W_RSTCTL) && softBit;
    end
  end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [WORD_W-1:0] wordIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              lockSta,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] storeQ [NUM_STORE];
  logic              ctrlBit;
  logic [DATA_W-1:0] rdNext;
  logic [DATA_W:0]   roHit;

  for (genvar i = 0; i < NUM_STORE; i++) begin : g_store
    localparam logic [WORD_W-1:0] IDX  = storeIdx(i);
    localparam logic [DATA_W-1:0] INIT = storeInit(i);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        storeQ[i] <= INIT;
      else if (stb.storeEn && wordIdx == IDX)
        storeQ[i] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      ctrlBit <= 1'b0;
    else if (stb.ctrlBitWr)
      ctrlBit <= wrData[0];
  end

  always_comb begin
    rdNext = '0;
    roHit  = roConst(wordIdx);
    if (wordIdx == W_CTRL)    rdNext[0] = ctrlBit;
    if (wordIdx == W_LOCKSTA) rdNext[0] = lockSta;
    if (roHit[DATA_W])        rdNext    = roHit[DATA_W-1:0];
    for (int i = 0; i < NUM_STORE; i++)
      if (wordIdx == storeIdx(i)) rdNext = storeQ[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rdData <= '0;
    else if (stb.rdLatch)
      rdData <= rdNext;
  end

endmodule

// File: rtl/sysctl_keylock_bank.sv
module sysctl_keylock_bank
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = BYTE_ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              accessErr,
  output logic              softRstReq
);

  logic [WORD_W-1:0] wordIdx;
  logic [1:0]        unusedByteLane;
  strobe_t           stb;
  logic              lockSta;

  assign wordIdx        = addr[WORD_W+1:2];
  assign unusedByteLane = addr[1:0];

  sysctl_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .wordIdx    (wordIdx),
    .keyBits    (wrData[KEY_W-1:0]),
    .softBit    (wrData[0]),
    .stb        (stb),
    .lockSta    (lockSta),
    .accessErr  (accessErr),
    .softRstReq (softRstReq)
  );

  sysctl_regs u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wordIdx (wordIdx),
    .wrData  (wrData),
    .lockSta (lockSta),
    .rdData  (rdData)
  );

endmodule

// File: rtl/sysctl_keylock_chk.sv
module sysctl_keylock_chk
  import sysctl_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [WORD_W-1:0] wordIdx,
  input logic [DATA_W-1:0] wrData,
  input logic              lockSta,
  input logic              accessErr,
  input logic              softRstReq
);

  // R3
  lock_key_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wordIdx == W_LOCK && wrData[KEY_W-1:0] == LOCK_KEY) |=> lockSta);

  // R3
  unlock_key_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wordIdx == W_UNLOCK && wrData[KEY_W-1:0] == UNLOCK_KEY) |=> !lockSta);

  // R3
  lock_only_by_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lockSta) |-> $past(wrEn && (wordIdx == W_LOCK || wordIdx == W_UNLOCK)));

  // R4
  locked_write_flagged_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && lockSta && wordIdx == 10'h040) |=> accessErr);

  // R8
  err_has_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    accessErr |-> $past(wrEn || rdEn));

  // R9
  soft_rst_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    softRstReq |-> ($past(wrEn) && $past(wordIdx) == W_RSTCTL && $past(wrData[0])
                    && !$past(lockSta)));

endmodule

bind sysctl_keylock_bank sysctl_keylock_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .rdEn       (rdEn),
  .wordIdx    (wordIdx),
  .wrData     (wrData),
  .lockSta    (lockSta),
  .accessErr  (accessErr),
  .softRstReq (softRstReq)
);

// File: tb/sim_sysctl_keylock_bank.sv
module sim_sysctl_keylock_bank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        accessErr;
  logic        softRstReq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  sysctl_keylock_bank u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .accessErr(accessErr), .softRstReq(softRstReq)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000) begin
      errors = errors + 1;
      $display("FAIL watchdog (all requirements) actual=%0d cycles expected=completion", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  typedef struct packed {
    logic        isWr;
    logic [11:0] a;
    logic [31:0] d;
    logic [31:0] exp;
    logic        expErr;
    logic        expRst;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'h00C, 32'h0,        32'h00000001, 1'b0, 1'b0, 4'd1},  // R1 locked at reset
    '{1'b0, 12'h100, 32'h0,        32'h0001A008, 1'b0, 1'b0, 4'd1},  // R1
    '{1'b0, 12'h114, 32'h0,        32'h00014000, 1'b0, 1'b0, 4'd1},  // R1
    '{1'b0, 12'h10C, 32'h0,        32'h0000003F, 1'b0, 1'b0, 4'd1},  // R1
    '{1'b0, 12'h25C, 32'h0,        32'h00000001, 1'b0, 1'b0, 4'd1},  // R1
    '{1'b0, 12'h250, 32'h0,        32'h00000040, 1'b0, 1'b0, 4'd1},  // R1
    '{1'b0, 12'h120, 32'h0,        32'h00000000, 1'b0, 1'b0, 4'd1},  // R1
    '{1'b1, 12'h100, 32'h12345678, 32'h0,        1'b1, 1'b0, 4'd4},  // R4 locked
    '{1'b0, 12'h100, 32'h0,        32'h0001A008, 1'b0, 1'b0, 4'd4},  // R4
    '{1'b1, 12'h000, 32'hFFFFFFFF, 32'h0,        1'b0, 1'b0, 4'd5},  // R5
    '{1'b0, 12'h000, 32'h0,        32'h00000001, 1'b0, 1'b0, 4'd5},  // R5
    '{1'b1, 12'h008, 32'h00001234, 32'h0,        1'b0, 1'b0, 4'd3},  // R3 wrong key
    '{1'b0, 12'h00C, 32'h0,        32'h00000001, 1'b0, 1'b0, 4'd3},  // R3
    '{1'b1, 12'h008, 32'hABCDDF0D, 32'h0,        1'b0, 1'b0, 4'd3},  // R3 unlock
    '{1'b0, 12'h00C, 32'h0,        32'h00000000, 1'b0, 1'b0, 4'd3},  // R3
    '{1'b1, 12'h100, 32'h12345678, 32'h0,        1'b0, 1'b0, 4'd10}, // R10
    '{1'b0, 12'h103, 32'h0,        32'h12345678, 1'b0, 1'b0, 4'd2},  // R2 low bits
    '{1'b1, 12'h10C, 32'h0,        32'h0,        1'b1, 1'b0, 4'd6},  // R6 read-only
    '{1'b0, 12'h10C, 32'h0,        32'h0000003F, 1'b0, 1'b0, 4'd6},  // R6
    '{1'b1, 12'h00C, 32'h0,        32'h0,        1'b1, 1'b0, 4'd6},  // R6 lock status RO
    '{1'b1, 12'h3FC, 32'h0000FFFF, 32'h0,        1'b1, 1'b0, 4'd6},  // R6 unmapped
    '{1'b0, 12'h3FC, 32'h0,        32'h00000000, 1'b1, 1'b0, 4'd7},  // R7 unmapped
    '{1'b0, 12'h004, 32'h0,        32'h00000000, 1'b1, 1'b0, 4'd7},  // R7 write-only
    '{1'b0, 12'h60C, 32'h0,        32'h00000000, 1'b1, 1'b0, 4'd7},  // R7
    '{1'b1, 12'h200, 32'h00000003, 32'h0,        1'b0, 1'b1, 4'd9},  // R9 pulse
    '{1'b0, 12'h200, 32'h0,        32'h00000003, 1'b0, 1'b0, 4'd9},  // R9 stored
    '{1'b1, 12'h200, 32'h00000002, 32'h0,        1'b0, 1'b0, 4'd9},  // R9 bit0 clear
    '{1'b1, 12'h250, 32'hCAFEF00D, 32'h0,        1'b0, 1'b0, 4'd10}, // R10
    '{1'b0, 12'h250, 32'h0,        32'hCAFEF00D, 1'b0, 1'b0, 4'd10}, // R10
    '{1'b1, 12'h004, 32'h0000767B, 32'h0,        1'b0, 1'b0, 4'd3},  // R3 relock
    '{1'b0, 12'h00C, 32'h0,        32'h00000001, 1'b0, 1'b0, 4'd3},  // R3
    '{1'b1, 12'h200, 32'h00000001, 32'h0,        1'b1, 1'b0, 4'd9},  // R9 locked
    '{1'b0, 12'h200, 32'h0,        32'h00000002, 1'b0, 1'b0, 4'd9},  // R9
    '{1'b1, 12'h000, 32'h00000000, 32'h0,        1'b0, 1'b0, 4'd5},  // R5 locked clear
    '{1'b1, 12'h60C, 32'h00000001, 32'h0,        1'b1, 1'b0, 4'd4}   // R4 write-only locked
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%08h expected=%08h", req, act, expv);
    end
  endtask

  task automatic doOp(input logic w, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = w; rdEn = !w; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs idle after reset
    check(rdData == 0, "R1 rdData", rdData, 0);
    check(accessErr == 0, "R1 accessErr", {31'b0, accessErr}, 0);
    check(softRstReq == 0, "R1 softRstReq", {31'b0, softRstReq}, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      doOp(VEC[i].isWr, VEC[i].a, VEC[i].d);
      if (!VEC[i].isWr)
        check(rdData == VEC[i].exp, $sformatf("R%0d vec%0d rdData", VEC[i].req, i),
              rdData, VEC[i].exp);
      check(accessErr == VEC[i].expErr, $sformatf("R%0d vec%0d accessErr", VEC[i].req, i),
            {31'b0, accessErr}, {31'b0, VEC[i].expErr});
      check(softRstReq == VEC[i].expRst, $sformatf("R%0d vec%0d softRstReq", VEC[i].req, i),
            {31'b0, softRstReq}, {31'b0, VEC[i].expRst});
    end

    // R5 control bit cleared while locked
    doOp(1'b0, 12'h000, 32'h0);
    check(rdData == 0, "R5 ctrl cleared while locked", rdData, 0);

    // R8 error pulse lasts one cycle
    doOp(1'b0, 12'h004, 32'h0);
    check(accessErr == 1'b1, "R8 pulse high", {31'b0, accessErr}, 1);
    @(negedge clk);
    check(accessErr == 1'b0, "R8 pulse gone", {31'b0, accessErr}, 0);

    // R2 data not visible before the clock edge
    doOp(1'b0, 12'h00C, 32'h0);
    @(negedge clk);
    rdEn = 1'b1; addr = 12'h10C;
    #2;
    check(rdData == 32'h1, "R2 before edge", rdData, 32'h1);
    @(negedge clk);
    rdEn = 1'b0;
    check(rdData == 32'h3F, "R2 after edge", rdData, 32'h3F);

    // R1 mid-run reset restores lock and values
    doOp(1'b1, 12'h008, 32'h0000DF0D);
    doOp(1'b1, 12'h104, 32'h0BADBEEF);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    doOp(1'b0, 12'h104, 32'h0);
    check(rdData == 32'h0001A008, "R1 value after reset", rdData, 32'h0001A008);
    doOp(1'b0, 12'h00C, 32'h0);
    check(rdData == 32'h1, "R1 lock after reset", rdData, 32'h1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule